// File: doc/BRIEF.md
# Program Fetch Wait-State Manager

This block sits between a processor's fetch unit and three program stores: a size-configurable on-chip ROM window at the bottom of the first 64 kB, a size-configurable on-chip RAM window at the top of the first 64 kB, and slow off-chip memory that covers every other address of a 23-bit (8 MB) linear program space. For each request it picks one region and raises that region's read or write strobe. It also returns the matching read data to the fetch unit.

On-chip accesses finish in the cycle they are issued. An off-chip access holds the fetch unit through a `stall` output. The stall lasts for a programmed number of wait cycles. It then continues for as long as the external `ext_ready` input is low once that count has run out. Program writes go to the on-chip RAM or to off-chip memory. A write that lands in the ROM window is dropped. The requester keeps `req`, `we`, `addr` and `wdata` stable for as long as `stall` is high.

Top module: `pfetch_wait_mgr`

## Requirements
- R1: When `rom_size` is c ≠ 0 and `addr` is below 2^(9+c) with bits 22..16 zero, a read raises `rom_rd` in the same cycle, and `stall` stays low.
- R2: When `ram_size` is c ≠ 0 and `addr[15:0]` ≥ 65536 − 2^(9+c) with bits 22..16 zero, a read raises `ram_rd` in the same cycle, and `stall` stays low.
- R3: If the ROM and RAM windows overlap, an address inside both is decoded as ROM.
- R4: A size code of 0 removes that window, so its addresses go to off-chip memory.
- R5: Every address with any of bits 22..16 set goes to off-chip memory, whatever the size codes are.
- R6: With `ext_ready` high, an off-chip access that has wait count N holds `stall` high for exactly N cycles. Its strobe (`ext_rd` or `ext_we`) stays high for all N+1 cycles.
- R7: `ext_ready` is looked at only after the wait count has run out. Each cycle after that in which it is low adds one stall cycle. A low level while the count is still running adds nothing.
- R8: With wait count 0 and `ext_ready` high, an off-chip access completes in one cycle and `stall` never rises.
- R9: A write raises `ram_we` in the RAM window and `ext_we` off-chip, where it uses the same wait rules as a read. A write in the ROM window raises no strobe and no stall. At most one strobe is high in any cycle.
- R10: `rdata` carries the data input of the addressed region: `rom_rdata`, `ram_rdata` or `ext_rdata`. `ext_addr` is `addr` zero-extended to 24 bits, and `local_addr` is `addr[15:0]`.
- R11: After reset, and after a reset that cuts into an off-chip access, `stall` and all strobes are low while `req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, held stable while stalled |
| we | input | 1 | 1 = program write, 0 = fetch |
| addr | input | 23 | Linear program address |
| wdata | input | 8 | Write data |
| rom_size | input | 3 | ROM window size code (0 = absent, c → 2^(9+c) bytes) |
| ram_size | input | 3 | RAM window size code (0 = absent, c → 2^(9+c) bytes) |
| wait_cnt | input | 3 | Off-chip wait cycles |
| ext_ready | input | 1 | Off-chip ready, low extends the access |
| rom_rdata | input | 8 | Read data from on-chip ROM |
| ram_rdata | input | 8 | Read data from on-chip RAM |
| ext_rdata | input | 8 | Read data from off-chip memory |
| local_addr | output | 16 | Address for the on-chip arrays |
| rom_rd | output | 1 | On-chip ROM read strobe |
| ram_rd | output | 1 | On-chip RAM read strobe |
| ram_we | output | 1 | On-chip RAM write strobe |
| ext_addr | output | 24 | Off-chip address bus |
| ext_rd | output | 1 | Off-chip program read strobe |
| ext_we | output | 1 | Off-chip program write strobe |
| mem_wdata | output | 8 | Write data to either memory |
| rdata | output | 8 | Fetched data to the CPU |
| stall | output | 1 | Holds the fetch unit |

## Verification
The hardest case to reach is the handover from the counted wait to the ready-gated wait. Here `ext_ready` goes low partly during the count and partly after it, and the stall length must come out as the larger of the two, not their sum. The bench drives `ext_ready` cycle by cycle, low for the first L cycles of an access. It tries L below, equal to and above N, so the reading of ready both before and after the count runs out is tested. A reset asserted in the middle of a long off-chip access is also forced, to show that no stale count is left over.

// File: rtl/pfw_pkg.sv
package pfw_pkg;
   typedef enum logic [1:0] {
      RGN_ROM = 2'd0,
      RGN_RAM = 2'd1,
      RGN_EXT = 2'd2
   } region_e;
endpackage

// File: rtl/pfw_region_dec.sv
module pfw_region_dec
   import pfw_pkg::*;
#(
   parameter int ADDR_W    = 23,
   parameter int LOCAL_W   = 16,
   parameter int SIZE_W    = 3,
   parameter int SIZE_BASE = 9
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [SIZE_W-1:0] rom_size,
   input  logic [SIZE_W-1:0] ram_size,
   output region_e           region
);
   localparam int SPAN_W = LOCAL_W + 1;
   localparam logic [SPAN_W-1:0] SPAN = SPAN_W'(1) << LOCAL_W;

   logic              in_low;
   logic [SPAN_W-1:0] rom_bytes;
   logic [SPAN_W-1:0] ram_bytes;
   logic [SPAN_W-1:0] ram_base;
   logic [SPAN_W-1:0] offs;
   logic              hit_rom;
   logic              hit_ram;

   // upper address bits only exist when the space exceeds the local window
   generate
      if (ADDR_W > LOCAL_W) begin : g_high
         assign in_low = (addr[ADDR_W-1:LOCAL_W] == '0);
      end else begin : g_flat
         assign in_low = 1'b1;
      end
   endgenerate

   always_comb begin
      offs      = {1'b0, addr[LOCAL_W-1:0]};
      rom_bytes = (rom_size == '0) ? '0 : (SPAN_W'(1) << (SIZE_BASE + int'(rom_size)));
      ram_bytes = (ram_size == '0) ? '0 : (SPAN_W'(1) << (SIZE_BASE + int'(ram_size)));
      ram_base  = SPAN - ram_bytes;
      hit_rom   = in_low && (rom_size != '0) && (offs < rom_bytes);
      hit_ram   = in_low && (ram_size != '0) && (offs >= ram_base);
      if (hit_rom)      region = RGN_ROM;   // ROM wins on overlap
      else if (hit_ram) region = RGN_RAM;
      else              region = RGN_EXT;
   end
endmodule

// File: rtl/pfw_wait_seq.sv
module pfw_wait_seq #(
   parameter int WAIT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_access,
   input  logic [WAIT_W-1:0] wait_cnt,
   input  logic              ext_ready,
   output logic              stall
);
   logic              busy;
   logic [WAIT_W-1:0] cnt;
   logic [WAIT_W-1:0] remaining;
   logic              done;

   always_comb begin
      remaining = busy ? cnt : wait_cnt;
      done      = (remaining == '0) && ext_ready;
      stall     = ext_access && !done;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (ext_access && !done) begin
         busy <= 1'b1;
         cnt  <= (remaining != '0) ? remaining - WAIT_W'(1) : '0;
      end else begin
         busy <= 1'b0;
         cnt  <= '0;
      end
   end

   // R6: a running count always holds the requester
   p_count_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt != '0 && ext_access) |-> stall);
   // R6: the count moves down by one per stalled cycle
   p_count_steps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt != '0 && ext_access) |=> (cnt == $past(cnt) - WAIT_W'(1)));
   // R7: a low ready never lets an off-chip access finish
   p_ready_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_access && !ext_ready) |-> stall);
   // R6: a finished access leaves the sequencer idle
   p_finish_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_access && !stall) |=> !busy);
endmodule

// File: rtl/pfw_data_mux.sv
module pfw_data_mux
   import pfw_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  region_e           region,
   input  logic [DATA_W-1:0] rom_rdata,
   input  logic [DATA_W-1:0] ram_rdata,
   input  logic [DATA_W-1:0] ext_rdata,
   output logic [DATA_W-1:0] rdata
);
   always_comb begin
      unique case (region)
         RGN_ROM: rdata = rom_rdata;
         RGN_RAM: rdata = ram_rdata;
         default: rdata = ext_rdata;
      endcase
   end
endmodule

// File: rtl/pfetch_wait_mgr.sv
module pfetch_wait_mgr
   import pfw_pkg::*;
#(
   parameter int ADDR_W    = 23,
   parameter int LOCAL_W   = 16,
   parameter int DATA_W    = 8,
   parameter int SIZE_W    = 3,
   parameter int SIZE_BASE = 9,
   parameter int WAIT_W    = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req,
   input  logic                we,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [SIZE_W-1:0]   rom_size,
   input  logic [SIZE_W-1:0]   ram_size,
   input  logic [WAIT_W-1:0]   wait_cnt,
   input  logic                ext_ready,
   input  logic [DATA_W-1:0]   rom_rdata,
   input  logic [DATA_W-1:0]   ram_rdata,
   input  logic [DATA_W-1:0]   ext_rdata,
   output logic [LOCAL_W-1:0]  local_addr,
   output logic                rom_rd,
   output logic                ram_rd,
   output logic                ram_we,
   output logic [ADDR_W:0]     ext_addr,
   output logic                ext_rd,
   output logic                ext_we,
   output logic [DATA_W-1:0]   mem_wdata,
   output logic [DATA_W-1:0]   rdata,
   output logic                stall
);
   localparam int MAX_SHIFT = SIZE_BASE + (1 << SIZE_W) - 1;

   generate
      if (ADDR_W <= LOCAL_W) begin : g_chk_addr
         $error("ADDR_W must exceed LOCAL_W");
      end
      if (MAX_SHIFT > LOCAL_W) begin : g_chk_size
         $error("largest window exceeds the local span");
      end
      if (WAIT_W < 1 || DATA_W < 1) begin : g_chk_width
         $error("WAIT_W and DATA_W must be positive");
      end
   endgenerate

   region_e region;
   logic    ext_access;

   pfw_region_dec #(
      .ADDR_W(ADDR_W), .LOCAL_W(LOCAL_W), .SIZE_W(SIZE_W), .SIZE_BASE(SIZE_BASE)
   ) u_dec (
      .addr(addr), .rom_size(rom_size), .ram_size(ram_size), .region(region)
   );

   assign ext_access = req && (region == RGN_EXT);

   pfw_wait_seq #(.WAIT_W(WAIT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .ext_access(ext_access),
      .wait_cnt(wait_cnt), .ext_ready(ext_ready), .stall(stall)
   );

   pfw_data_mux #(.DATA_W(DATA_W)) u_mux (
      .region(region), .rom_rdata(rom_rdata), .ram_rdata(ram_rdata),
      .ext_rdata(ext_rdata), .rdata(rdata)
   );

   always_comb begin
      rom_rd = req && !we && (region == RGN_ROM);
      ram_rd = req && !we && (region == RGN_RAM);
      ram_we = req &&  we && (region == RGN_RAM);
      ext_rd = ext_access && !we;
      ext_we = ext_access &&  we;
   end

   assign local_addr = addr[LOCAL_W-1:0];
   assign ext_addr   = {1'b0, addr};
   assign mem_wdata  = wdata;

   // R9: never more than one memory strobe
   p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rom_rd, ram_rd, ram_we, ext_rd, ext_we}));
   // R1: on-chip strobes never come with a stall
   p_onchip_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_rd || ram_rd || ram_we) |-> !stall);
   // R6: stall only while an off-chip strobe is up
   p_stall_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (ext_rd || ext_we));
   // R6: while stalled the off-chip address does not move
   p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && req) |=> (!req || $stable(ext_addr)) || !rst_n);
   // R11: nothing happens without a request
   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !req |-> (!stall && !rom_rd && !ram_rd && !ram_we && !ext_rd && !ext_we));
endmodule

// File: tb/pfetch_wait_mgr_tb_top.sv
module pfetch_wait_mgr_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic        we = 1'b0;
   logic [22:0] addr = '0;
   logic [7:0]  wdata = 8'h5A;
   logic [2:0]  rom_size = 3'd1;
   logic [2:0]  ram_size = 3'd3;
   logic [2:0]  wait_cnt = '0;
   logic        ext_ready = 1'b1;
   logic [7:0]  rom_rdata = 8'hA1;
   logic [7:0]  ram_rdata = 8'hB2;
   logic [7:0]  ext_rdata = 8'hC3;
   logic [15:0] local_addr;
   logic        rom_rd, ram_rd, ram_we, ext_rd, ext_we, stall;
   logic [23:0] ext_addr;
   logic [7:0]  mem_wdata, rdata;

   int checks = 0;
   int errors = 0;
   bit ended  = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   pfetch_wait_mgr dut_i (
      .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
      .rom_size(rom_size), .ram_size(ram_size), .wait_cnt(wait_cnt),
      .ext_ready(ext_ready), .rom_rdata(rom_rdata), .ram_rdata(ram_rdata),
      .ext_rdata(ext_rdata), .local_addr(local_addr), .rom_rd(rom_rd),
      .ram_rd(ram_rd), .ram_we(ram_we), .ext_addr(ext_addr), .ext_rd(ext_rd),
      .ext_we(ext_we), .mem_wdata(mem_wdata), .rdata(rdata), .stall(stall)
   );

   // strobe code: 0 none, 1 rom_rd, 2 ram_rd, 3 ram_we, 4 ext_rd, 5 ext_we, 7 several
   function automatic int strobe_code();
      int n;
      n = int'(rom_rd) + int'(ram_rd) + int'(ram_we) + int'(ext_rd) + int'(ext_we);
      if (n > 1) return 7;
      if (rom_rd) return 1;
      if (ram_rd) return 2;
      if (ram_we) return 3;
      if (ext_rd) return 4;
      if (ext_we) return 5;
      return 0;
   endfunction

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // One access; ext_ready is low for the first lo cycles of it.
   task automatic run_access(input string tag, input bit w, input int rc, input int mc,
                             input int wt, input int a, input int lo,
                             input int exp_code, input int exp_stall);
      int n;
      int first_code;
      @(negedge clk);
      req = 1'b1; we = w; addr = 23'(a);
      rom_size = 3'(rc); ram_size = 3'(mc); wait_cnt = 3'(wt);
      ext_ready = (lo == 0);
      #1;
      first_code = strobe_code();
      check(tag, "first-cycle strobe", first_code, exp_code);
      n = 0;
      while (stall && n < 40) begin
         @(negedge clk);
         n++;
         ext_ready = (n >= lo);
         #1;
      end
      check(tag, "stall cycles", n, exp_stall);
      check(tag, "final-cycle strobe", strobe_code(), exp_code);
      if (!w && exp_code != 0)
         check(tag, "rdata", int'(rdata),
               exp_code == 1 ? 32'hA1 : exp_code == 2 ? 32'hB2 : 32'hC3);
      if (exp_code >= 4)
         check(tag, "ext_addr", int'(ext_addr), a);
      @(negedge clk);
      req = 1'b0; we = 1'b0; ext_ready = 1'b1;
   endtask

   // fields: tag[43:40] we[39] rom[38:36] ram[35:33] wait[32:30] addr[29:7] code[6:4] stall[3:0]
   localparam int NV = 16;
   localparam logic [43:0] VEC [NV] = '{
      {4'd1,  1'b0, 3'd1, 3'd3, 3'd0, 23'h000000, 3'd1, 4'd0},  // R1 ROM base
      {4'd1,  1'b0, 3'd1, 3'd3, 3'd0, 23'h0003FF, 3'd1, 4'd0},  // R1 ROM top byte
      {4'd6,  1'b0, 3'd1, 3'd3, 3'd2, 23'h000400, 3'd4, 4'd2},  // R6 just above ROM
      {4'd6,  1'b0, 3'd1, 3'd3, 3'd3, 23'h00EFFF, 3'd4, 4'd3},  // R6 just below RAM
      {4'd2,  1'b0, 3'd1, 3'd3, 3'd4, 23'h00F000, 3'd2, 4'd0},  // R2 RAM base
      {4'd2,  1'b0, 3'd1, 3'd3, 3'd4, 23'h00FFFF, 3'd2, 4'd0},  // R2 RAM top
      {4'd5,  1'b0, 3'd1, 3'd3, 3'd1, 23'h010000, 3'd4, 4'd1},  // R5 first byte above 64k
      {4'd5,  1'b0, 3'd7, 3'd7, 3'd5, 23'h7FFFFF, 3'd4, 4'd5},  // R5 top of space
      {4'd9,  1'b1, 3'd1, 3'd3, 3'd2, 23'h00F800, 3'd3, 4'd0},  // R9 RAM write
      {4'd9,  1'b1, 3'd1, 3'd3, 3'd2, 23'h000010, 3'd0, 4'd0},  // R9 ROM write dropped
      {4'd9,  1'b1, 3'd1, 3'd3, 3'd4, 23'h020000, 3'd5, 4'd4},  // R9 off-chip write
      {4'd4,  1'b0, 3'd0, 3'd3, 3'd2, 23'h000000, 3'd4, 4'd2},  // R4 ROM absent
      {4'd8,  1'b0, 3'd1, 3'd0, 3'd0, 23'h00FFFF, 3'd4, 4'd0},  // R8 RAM absent, zero wait
      {4'd3,  1'b0, 3'd7, 3'd3, 3'd0, 23'h00F000, 3'd1, 4'd0},  // R3 overlap goes to ROM
      {4'd1,  1'b0, 3'd4, 3'd3, 3'd0, 23'h001FFF, 3'd1, 4'd0},  // R1 8k ROM top byte
      {4'd6,  1'b0, 3'd4, 3'd3, 3'd7, 23'h002000, 3'd4, 4'd7}   // R6 longest count
   };

   initial begin
      repeat (20000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R11: reset state
      check("R11", "strobes in reset", strobe_code(), 0);
      check("R11", "stall in reset", int'(stall), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check("R11", "idle after reset", strobe_code() + int'(stall), 0);

      for (int i = 0; i < NV; i++) begin
         automatic logic [43:0] v = VEC[i];
         automatic string tag = $sformatf("R%0d", int'(v[43:40]));
         run_access(tag, v[39], int'(v[38:36]), int'(v[35:33]), int'(v[32:30]),
                    int'(v[29:7]), 0, int'(v[6:4]), int'(v[3:0]));
      end

      // R7: ready low beyond the count extends the stall
      run_access("R7", 1'b0, 1, 3, 2, 32'h030000, 5, 4, 5);
      // R7: ready low only while counting adds nothing
      run_access("R7", 1'b0, 1, 3, 3, 32'h030001, 2, 4, 3);
      // R7: ready low exactly as long as the count
      run_access("R7", 1'b0, 1, 3, 3, 32'h030002, 3, 4, 3);
      // R7 with R8: zero wait, ready low three cycles
      run_access("R7", 1'b0, 1, 3, 0, 32'h000800, 3, 4, 3);

      // R10: address outputs and write data path
      @(negedge clk);
      req = 1'b1; we = 1'b1; addr = 23'h00F123; wdata = 8'h3C;
      rom_size = 3'd1; ram_size = 3'd3;
      #1;
      check("R10", "local_addr", int'(local_addr), 32'hF123);
      check("R10", "mem_wdata", int'(mem_wdata), 32'h3C);
      check("R10", "ext_addr", int'(ext_addr), 32'h00F123);
      @(negedge clk);
      req = 1'b0; we = 1'b0;

      // R11: reset inside a long off-chip access leaves no stale count
      @(negedge clk);
      req = 1'b1; addr = 23'h040000; wait_cnt = 3'd7; ext_ready = 1'b1;
      repeat (2) @(negedge clk);
      rst_n = 1'b0; req = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R11", "stall after mid-access reset", int'(stall), 0);
      check("R11", "strobes after mid-access reset", strobe_code(), 0);
      // a following zero-wait off-chip read must finish at once (R8)
      run_access("R8", 1'b0, 1, 3, 0, 32'h040000, 0, 4, 0);

      ended = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule